// File: doc/BRIEF.md
# ALU Bundle Read-Port Conflict Checker

This block inspects one instruction bundle of a VLIW shader ALU before it issues and decides whether the bundle can legally read its source operands. A bundle has up to four vector slots (x, y, z, w) and one transcendental slot. Each slot carries up to three source operands. Each operand has a 9-bit select and a 2-bit component, and each slot has a 3-bit swizzle code. The register file is banked by component. Each bundle gets three read cycles, and in each cycle every component bank can deliver one register value. The swizzle code of a slot places each of its operands in one of those cycles.

The checker flags five distinct violations and raises a legal bit when none of them occurs. The bundle enters on a valid/ready input. Its verdict leaves one cycle later on a valid/ready output. Back-pressure works as follows: `in_ready` is high whenever no verdict is held, or when the held verdict is taken in the same cycle. A verdict stays on the outputs, unchanged, until `out_ready` is seen high together with `out_valid`. The swizzle tables assume three sources per slot.

Top module: `alu_bundle_checker`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A bundle accepted at a clock edge (`in_valid && in_ready`) has its verdict on the outputs with `out_valid` high after that edge. While `out_valid && !out_ready`, `out_valid`, `out_legal` and `out_err` hold their values.
- R2: While reset is low and after it is released, `out_valid` is 0 until a bundle is accepted.
- R3: Slot order is x, y, z, w, trans (slot index 0 to 4). Slots that follow the first slot with its last bit set are ignored. When no last bit is set, all five slots count. Operand j of a slot counts only when j is below that slot's 2-bit source count.
- R4: Operand classes are decided by the select:
  - 0 to 127 is a GPR index.
  - 128 to 191 is a constant-cache entry.
  - 252 and 253 are the previous vector and previous scalar results.
  - The other values from 248 to 255 are inline constants.
  - 192 to 247 have no effect at all.
  - Only GPR operands use read ports.
- R5: Vector swizzle codes 0 to 5 give the cycle orders (src0, src1, src2) = 012, 021, 120, 102, 201 and 210. Codes 6 and 7 behave as code 0.
- R6: Trans swizzle codes use their two low bits: 0 gives 210, 1 gives 120, 2 gives 201 and 3 gives 222. The trans slot shares the vector slots' ports.
- R7: Error bit 0 (port) is set when two counted GPR reads fall in the same cycle and the same component but name different GPR indices. Reads of the same index and component in the same cycle share one port.
- R8: When src0 and src1 of a counted slot are both GPRs with equal index and component, src1 is left out of the port and trans-cycle rules.
- R9: Error bit 1 is set when the bundle names more than 3 distinct GPR indices. Components do not matter for this count.
- R10: Error bit 2 is set when the bundle uses more than 4 distinct constant-cache (select, component) pairs.
- R11: Error bit 3 is set when the trans slot uses more than 2 distinct constants. A constant here is either a constant-cache or an inline operand, counted by (select, component).
- R12: Error bit 4 is set when a trans GPR or previous-result read breaks the cycle limit:
  - With exactly one trans constant, such a read may not fall in cycle 0.
  - With two or more trans constants, such a read is allowed only in cycle 2.
- R13: `out_legal` is 1 exactly when all five error bits of the same verdict are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be taken |
| in_last | input | 5 | Per-slot end-of-bundle bit, slot 0 = x |
| in_nsrc | input | 10 | Per-slot source count, 2 bits per slot |
| in_swz | input | 15 | Per-slot swizzle code, 3 bits per slot |
| in_sel | input | 135 | Operand selects, 9 bits each, operand = slot*3+src |
| in_comp | input | 30 | Operand components, 2 bits each |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Verdict taken |
| out_legal | output | 1 | Bundle legal |
| out_err | output | 5 | Error flags: port, GPR count, constant count, trans constants, trans cycle |

## Verification
The bench builds the block with its default parameters: four vector slots, three sources, 9-bit selects and limits of 3 GPRs, 4 cache constants and 2 trans constants. These values keep the GPR and constant limits within reach of small operand pools. Random bundles drawn from six GPR indices and four cache entries therefore hit every limit and every port collision often. The small pools also make the square exemption and the trans cycle windows reachable by chance, in addition to the directed cases.

// File: rtl/alu_chk_pkg.sv
package alu_chk_pkg;
  localparam int ERR_W  = 5;
  localparam int E_PORT = 0;
  localparam int E_GPR  = 1;
  localparam int E_KC   = 2;
  localparam int E_TKC  = 3;
  localparam int E_TCYC = 4;

  localparam int GPR_TOP = 127;
  localparam int KC_LO   = 128;
  localparam int KC_HI   = 191;
  localparam int INL_LO  = 248;
  localparam int SEL_PV  = 252;
  localparam int SEL_PS  = 253;

  // cycle order packed as {cyc(src0), cyc(src1), cyc(src2)}
  function automatic logic [1:0] vec_cycle(input logic [2:0] code, input int src);
    logic [5:0] ord;
    case (code)
      3'd1:    ord = 6'b00_10_01;
      3'd2:    ord = 6'b01_10_00;
      3'd3:    ord = 6'b01_00_10;
      3'd4:    ord = 6'b10_00_01;
      3'd5:    ord = 6'b10_01_00;
      default: ord = 6'b00_01_10;
    endcase
    return ord[(2 - src) * 2 +: 2];
  endfunction

  function automatic logic [1:0] trans_cycle(input logic [2:0] code, input int src);
    logic [5:0] ord;
    case (code)
      3'd0, 3'd4: ord = 6'b10_01_00;
      3'd1, 3'd5: ord = 6'b01_10_00;
      3'd2, 3'd6: ord = 6'b10_00_01;
      default:    ord = 6'b10_10_10;
    endcase
    return ord[(2 - src) * 2 +: 2];
  endfunction
endpackage

// File: rtl/op_classify.sv
module op_classify
  import alu_chk_pkg::*;
#(
  parameter int SEL_W    = 9,
  parameter int SRC_IDX  = 0,
  parameter bit IS_TRANS = 1'b0
) (
  input  logic             en,
  input  logic             skip,
  input  logic [SEL_W-1:0] sel,
  input  logic [2:0]       swz,
  output logic             gpr_rd,
  output logic             kc,
  output logic             tr_const,
  output logic             tr_read,
  output logic [1:0]       cyc
);
  localparam logic [SEL_W-1:0] L_GPR_TOP = SEL_W'(GPR_TOP);
  localparam logic [SEL_W-1:0] L_KC_LO   = SEL_W'(KC_LO);
  localparam logic [SEL_W-1:0] L_KC_HI   = SEL_W'(KC_HI);
  localparam logic [SEL_W-1:0] L_INL_LO  = SEL_W'(INL_LO);
  localparam logic [SEL_W-1:0] L_PV      = SEL_W'(SEL_PV);
  localparam logic [SEL_W-1:0] L_PS      = SEL_W'(SEL_PS);

  logic is_gpr, is_kc, is_prev, is_inl;

  assign is_gpr  = sel <= L_GPR_TOP;
  assign is_kc   = (sel >= L_KC_LO) && (sel <= L_KC_HI);
  assign is_prev = (sel == L_PV) || (sel == L_PS);
  assign is_inl  = (sel >= L_INL_LO) && !is_prev;

  assign gpr_rd   = en && !skip && is_gpr;
  assign kc       = en && is_kc;
  assign tr_const = IS_TRANS && en && (is_kc || is_inl);
  assign tr_read  = IS_TRANS && (gpr_rd || (en && is_prev));
  assign cyc      = IS_TRANS ? trans_cycle(swz, SRC_IDX) : vec_cycle(swz, SRC_IDX);
endmodule

// File: rtl/distinct_counter.sv
module distinct_counter #(
  parameter int N  = 15,
  parameter int KW = 9,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]    valid,
  input  logic [N*KW-1:0] keys,
  output logic [CW-1:0]   count
);
  logic [N-1:0] first;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      first[i] = valid[i];
      for (int k = 0; k < i; k++)
        if (valid[k] && keys[k*KW +: KW] == keys[i*KW +: KW]) first[i] = 1'b0;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) count = count + 1'b1;
  end
endmodule

// File: rtl/port_conflict.sv
module port_conflict #(
  parameter int N      = 15,
  parameter int SEL_W  = 9,
  parameter int COMP_W = 2
) (
  input  logic [N-1:0]        rd,
  input  logic [N*SEL_W-1:0]  sel,
  input  logic [N*COMP_W-1:0] comp,
  input  logic [N*2-1:0]      cyc,
  output logic                conflict
);
  always_comb begin
    conflict = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (rd[a] && rd[b] &&
            cyc[a*2 +: 2] == cyc[b*2 +: 2] &&
            comp[a*COMP_W +: COMP_W] == comp[b*COMP_W +: COMP_W] &&
            sel[a*SEL_W +: SEL_W] != sel[b*SEL_W +: SEL_W])
          conflict = 1'b1;
  end
endmodule

// File: rtl/alu_bundle_checker.sv
module alu_bundle_checker
  import alu_chk_pkg::*;
#(
  parameter int NVEC      = 4,
  parameter int NSRC      = 3,
  parameter int SEL_W     = 9,
  parameter int COMP_W    = 2,
  parameter int GPR_MAX   = 3,
  parameter int KC_MAX    = 4,
  parameter int TR_KC_MAX = 2,
  localparam int NSLOT    = NVEC + 1,
  localparam int NOPS     = NSLOT * NSRC,
  localparam int NSRC_W   = $clog2(NSRC + 1),
  localparam int SWZ_W    = 3,
  localparam int KEY_W    = SEL_W + COMP_W,
  localparam int CNT_W    = $clog2(NOPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NSLOT-1:0]         in_last,
  input  logic [NSLOT*NSRC_W-1:0]  in_nsrc,
  input  logic [NSLOT*SWZ_W-1:0]   in_swz,
  input  logic [NOPS*SEL_W-1:0]    in_sel,
  input  logic [NOPS*COMP_W-1:0]   in_comp,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_legal,
  output logic [ERR_W-1:0]         out_err
);
  logic [NSLOT-1:0]    slot_act;
  logic [NOPS-1:0]     gpr_rd, kc_v, tconst_v, tread_v;
  logic [NOPS*2-1:0]   cyc_v;
  logic [NOPS*KEY_W-1:0] key_v;
  logic [CNT_W-1:0]    gpr_cnt, kc_cnt, tkc_cnt;
  logic                port_err, tcyc_err;
  logic [ERR_W-1:0]    err_c;

  // slots after the first last bit are dropped
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      slot_act[s] = !seen;
      seen = seen | in_last[s];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [NSRC-1:0] en;
    logic            square;
    for (genvar j = 0; j < NSRC; j++) begin : g_en
      assign en[j] = slot_act[s] && (in_nsrc[s*NSRC_W +: NSRC_W] > NSRC_W'(j));
    end
    assign square = en[0] && en[1] &&
                    (in_sel[(s*NSRC)*SEL_W +: SEL_W] <= SEL_W'(GPR_TOP)) &&
                    (in_sel[(s*NSRC)*SEL_W +: SEL_W] == in_sel[(s*NSRC+1)*SEL_W +: SEL_W]) &&
                    (in_comp[(s*NSRC)*COMP_W +: COMP_W] == in_comp[(s*NSRC+1)*COMP_W +: COMP_W]);

    for (genvar j = 0; j < NSRC; j++) begin : g_op
      localparam int O = s * NSRC + j;
      op_classify #(
        .SEL_W   (SEL_W),
        .SRC_IDX (j),
        .IS_TRANS(s == NVEC)
      ) u_cls (
        .en      (en[j]),
        .skip    (j == 1 && square),
        .sel     (in_sel[O*SEL_W +: SEL_W]),
        .swz     (in_swz[s*SWZ_W +: SWZ_W]),
        .gpr_rd  (gpr_rd[O]),
        .kc      (kc_v[O]),
        .tr_const(tconst_v[O]),
        .tr_read (tread_v[O]),
        .cyc     (cyc_v[O*2 +: 2])
      );
      assign key_v[O*KEY_W +: KEY_W] = {in_sel[O*SEL_W +: SEL_W], in_comp[O*COMP_W +: COMP_W]};
    end
  end

  distinct_counter #(.N(NOPS), .KW(SEL_W)) u_gpr_cnt (
    .valid(gpr_rd), .keys(in_sel), .count(gpr_cnt)
  );
  distinct_counter #(.N(NOPS), .KW(KEY_W)) u_kc_cnt (
    .valid(kc_v), .keys(key_v), .count(kc_cnt)
  );
  distinct_counter #(.N(NOPS), .KW(KEY_W)) u_tkc_cnt (
    .valid(tconst_v), .keys(key_v), .count(tkc_cnt)
  );
  port_conflict #(.N(NOPS), .SEL_W(SEL_W), .COMP_W(COMP_W)) u_ports (
    .rd(gpr_rd), .sel(in_sel), .comp(in_comp), .cyc(cyc_v), .conflict(port_err)
  );

  // trans reads restricted by how many constants the trans slot holds
  always_comb begin
    tcyc_err = 1'b0;
    for (int o = 0; o < NOPS; o++) begin
      if (tread_v[o] && tkc_cnt == CNT_W'(1) && cyc_v[o*2 +: 2] == 2'd0) tcyc_err = 1'b1;
      if (tread_v[o] && tkc_cnt >= CNT_W'(2) && cyc_v[o*2 +: 2] != 2'd2) tcyc_err = 1'b1;
    end
  end

  always_comb begin
    err_c         = '0;
    err_c[E_PORT] = port_err;
    err_c[E_GPR]  = gpr_cnt > CNT_W'(GPR_MAX);
    err_c[E_KC]   = kc_cnt > CNT_W'(KC_MAX);
    err_c[E_TKC]  = tkc_cnt > CNT_W'(TR_KC_MAX);
    err_c[E_TCYC] = tcyc_err;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_legal <= 1'b0;
      out_err   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_legal <= ~|err_c;
      out_err   <= err_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module alu_bundle_checker_sva
  import alu_chk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_legal,
  input logic [ERR_W-1:0] out_err
);
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_err) && $stable(out_legal));

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r13_legal_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_legal == (out_err == '0)));
endmodule

bind alu_bundle_checker alu_bundle_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal), .out_err(out_err)
);

// File: tb/alu_bundle_checker_bench.sv
module alu_bundle_checker_bench;
  localparam int NSLOT = 5;
  localparam int NSRC  = 3;
  localparam int NOPS  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [4:0]   in_last = '0;
  logic [9:0]   in_nsrc = '0;
  logic [14:0]  in_swz = '0;
  logic [134:0] in_sel = '0;
  logic [29:0]  in_comp = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic out_legal;
  logic [4:0] out_err;

  always #5 clk = ~clk;

  alu_bundle_checker u_alu_bundle_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_nsrc(in_nsrc), .in_swz(in_swz), .in_sel(in_sel),
    .in_comp(in_comp), .out_valid(out_valid), .out_ready(out_ready),
    .out_legal(out_legal), .out_err(out_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit monitor_on = 1'b0;

  int b_sel [NOPS];
  int b_comp[NOPS];
  int b_swz [NSLOT];
  int b_nsrc[NSLOT];
  bit b_last[NSLOT];

  logic [4:0] exp_q[$];
  string      tag_q[$];

  int vord[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,2,0}, '{1,0,2}, '{2,0,1}, '{2,1,0}};
  int tord[4][3] = '{'{2,1,0}, '{1,2,0}, '{2,0,1}, '{2,2,2}};

  task automatic check(string what, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", what, got, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NOPS; i++) begin b_sel[i] = 0; b_comp[i] = 0; end
    for (int s = 0; s < NSLOT; s++) begin b_swz[s] = 0; b_nsrc[s] = 0; b_last[s] = 1'b0; end
  endtask

  task automatic op(int s, int j, int sel, int comp);
    b_sel[s*NSRC+j] = sel;
    b_comp[s*NSRC+j] = comp;
    if (b_nsrc[s] < j + 1) b_nsrc[s] = j + 1;
  endtask

  task automatic pack();
    for (int s = 0; s < NSLOT; s++) begin
      in_last[s] = b_last[s];
      in_nsrc[s*2 +: 2] = 2'(b_nsrc[s]);
      in_swz[s*3 +: 3] = 3'(b_swz[s]);
    end
    for (int i = 0; i < NOPS; i++) begin
      in_sel[i*9 +: 9] = 9'(b_sel[i]);
      in_comp[i*2 +: 2] = 2'(b_comp[i]);
    end
  endtask

  function automatic int cyc_of(int s, int j);
    if (s == NSLOT - 1) return tord[b_swz[s] % 4][j];
    return vord[(b_swz[s] > 5) ? 0 : b_swz[s]][j];
  endfunction

  function automatic bit is_gpr(int sel); return sel < 128; endfunction
  function automatic bit is_kc(int sel); return sel >= 128 && sel <= 191; endfunction
  function automatic bit is_prev(int sel); return sel == 252 || sel == 253; endfunction
  function automatic bit is_inl(int sel); return sel >= 248 && !is_prev(sel); endfunction

  // reference: enumerate port ownership per (cycle, bank)
  function automatic logic [4:0] model();
    int port[3][4];
    bit gseen[128];
    bit kseen[256];
    int tlist[3];
    int ng = 0, nk = 0, nt = 0;
    bit act[NSLOT];
    bit stop = 1'b0;
    logic [4:0] e = '0;
    for (int c = 0; c < 3; c++) for (int b = 0; b < 4; b++) port[c][b] = -1;
    for (int i = 0; i < 128; i++) gseen[i] = 1'b0;
    for (int i = 0; i < 256; i++) kseen[i] = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin act[s] = !stop; if (b_last[s]) stop = 1'b1; end
    if (act[4]) begin
      for (int j = 0; j < b_nsrc[4]; j++) begin
        int sel = b_sel[12+j];
        if (is_kc(sel) || is_inl(sel)) begin
          int key = sel * 4 + b_comp[12+j];
          bit dup = 1'b0;
          for (int k = 0; k < nt; k++) if (tlist[k] == key) dup = 1'b1;
          if (!dup) begin tlist[nt] = key; nt++; end
        end
      end
    end
    for (int s = 0; s < NSLOT; s++) begin
      if (!act[s]) continue;
      for (int j = 0; j < b_nsrc[s]; j++) begin
        int o = s * NSRC + j;
        int sel = b_sel[o];
        int cy = cyc_of(s, j);
        bit sq = (j == 1) && is_gpr(b_sel[o-1]) && b_sel[o-1] == sel && b_comp[o-1] == b_comp[o];
        if (is_gpr(sel)) begin
          if (!gseen[sel]) begin gseen[sel] = 1'b1; ng++; end
          if (!sq) begin
            if (port[cy][b_comp[o]] < 0) port[cy][b_comp[o]] = sel;
            else if (port[cy][b_comp[o]] != sel) e[0] = 1'b1;
          end
        end
        if (is_kc(sel)) begin
          int key = (sel - 128) * 4 + b_comp[o];
          if (!kseen[key]) begin kseen[key] = 1'b1; nk++; end
        end
        if (s == 4 && ((is_gpr(sel) && !sq) || is_prev(sel))) begin
          if (nt == 1 && cy == 0) e[4] = 1'b1;
          if (nt >= 2 && cy != 2) e[4] = 1'b1;
        end
      end
    end
    if (ng > 3) e[1] = 1'b1;
    if (nk > 4) e[2] = 1'b1;
    if (nt > 2) e[3] = 1'b1;
    return e;
  endfunction

  // driver: offer bundle, push expectation when accepted
  task automatic send(string tag, logic [4:0] exp);
    pack();
    in_valid = 1'b1;
    forever begin
      #2;
      if (in_ready) begin
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
        return;
      end
      @(negedge clk);
    end
  endtask

  // monitor: random back-pressure, pop and compare, check holding
  initial begin
    logic       held = 1'b0;
    logic [5:0] held_v = '0;
    wait (monitor_on);
    forever begin
      @(negedge clk);
      if (held) check("R1 verdict held under back-pressure", {out_valid, out_legal, out_err}, {1'b1, held_v[4:0] == 5'd0, held_v[4:0]});
      out_ready = ($urandom % 3) != 0;
      #2;
      check("R1 in_ready follows output state", {5'd0, in_ready}, {5'd0, !out_valid || out_ready});
      held = out_valid && !out_ready;
      held_v = {out_legal, out_err};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected verdict got %b expected none", out_err);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check($sformatf("%s R13", t), {out_legal, out_err}, {e == 5'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset out_valid", {5'd0, out_valid}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", {4'd0, out_valid, in_ready}, 6'd1);
    monitor_on = 1'b1;

    clr(); send("R3 empty bundle", 5'h00);
    // R7 / R5
    clr(); op(0,0,1,0); op(1,0,2,0); send("R7 two gprs same bank cycle0", 5'h01);
    clr(); op(0,0,1,0); op(1,0,2,0); b_swz[1] = 2; send("R5 code2 moves src0 to cycle1", 5'h00);
    clr(); op(0,0,1,0); op(1,0,2,0); b_swz[1] = 6; send("R5 code6 acts as code0", 5'h01);
    clr(); op(0,0,1,0); op(1,0,1,0); send("R7 shared read", 5'h00);
    // R8
    clr(); op(0,0,3,1); op(0,1,3,1); op(1,0,4,1); b_swz[1] = 3; send("R8 square src1 exempt", 5'h00);
    clr(); op(0,0,3,1); op(0,1,3,1); op(1,0,4,1); send("R8 square src0 still counts", 5'h01);
    // R9
    clr(); op(0,0,1,0); op(0,1,2,1); op(0,2,3,2); op(1,0,4,3); send("R9 four gprs", 5'h02);
    clr(); op(0,0,1,0); op(0,1,1,1); op(0,2,2,2); op(1,0,3,3); send("R9 three gpr indices", 5'h00);
    // R10
    clr(); op(0,0,128,0); op(0,1,129,0); op(0,2,130,0); op(1,0,131,0); op(1,1,128,1); send("R10 five constants", 5'h04);
    clr(); op(0,0,128,0); op(0,1,129,0); op(0,2,130,0); op(1,0,131,0); op(1,1,128,0); send("R10 four distinct", 5'h00);
    // R4
    clr(); op(0,0,252,0); op(1,0,1,0); send("R4 prev result takes no port", 5'h00);
    clr(); op(0,0,200,0); op(0,1,201,0); op(0,2,202,0); op(1,0,203,0); op(1,1,204,0); op(2,0,205,0); send("R4 reserved selects ignored", 5'h00);
    // R11
    clr(); op(4,0,128,0); op(4,1,129,0); op(4,2,248,0); send("R11 three trans constants", 5'h08);
    clr(); op(4,0,248,0); op(4,1,248,0); op(4,2,128,0); send("R11 two distinct trans constants", 5'h00);
    // R12
    clr(); op(4,0,128,0); op(4,1,1,0); b_swz[4] = 2; send("R12 one const gpr in cycle0", 5'h10);
    clr(); op(4,0,128,0); op(4,1,1,0); b_swz[4] = 0; send("R12 one const gpr in cycle1", 5'h00);
    clr(); op(4,0,128,0); op(4,1,129,0); op(4,2,1,0); b_swz[4] = 1; send("R12 two const gpr cycle0", 5'h10);
    clr(); op(4,0,128,0); op(4,1,129,0); op(4,2,1,0); b_swz[4] = 3; send("R12 two const gpr cycle2", 5'h00);
    clr(); op(4,0,128,0); op(4,1,252,0); b_swz[4] = 2; send("R12 R4 prev result in cycle0", 5'h10);
    // R6
    clr(); op(0,0,1,0); op(4,0,5,1); op(4,1,2,0); b_swz[4] = 2; send("R6 trans shares ports", 5'h01);
    clr(); op(0,0,1,0); op(4,0,5,1); op(4,1,2,0); b_swz[4] = 6; send("R6 trans code uses low bits", 5'h01);
    clr(); op(0,0,1,0); op(4,0,5,1); op(4,1,2,0); b_swz[4] = 0; send("R6 trans code0 cycle1", 5'h00);
    // R3
    clr(); op(0,0,1,0); op(1,0,2,0); b_last[0] = 1'b1; send("R3 slots after last ignored", 5'h00);
    clr(); op(0,0,1,0); op(1,0,2,0); b_last[1] = 1'b1; send("R3 last on y keeps y", 5'h01);
    clr(); op(0,0,1,0); op(1,0,2,0); b_nsrc[1] = 0; send("R3 operand beyond count ignored", 5'h00);

    for (int n = 0; n < 300; n++) begin
      clr();
      for (int s = 0; s < NSLOT; s++) begin
        b_nsrc[s] = $urandom % 4;
        b_swz[s] = $urandom % 8;
        b_last[s] = ($urandom % 6) == 0;
      end
      for (int i = 0; i < NOPS; i++) begin
        int r = $urandom % 16;
        if (r < 8)       b_sel[i] = $urandom % 6;
        else if (r < 12) b_sel[i] = 128 + $urandom % 4;
        else if (r == 12) b_sel[i] = 248 + $urandom % 2;
        else if (r == 13) b_sel[i] = 252;
        else if (r == 14) b_sel[i] = 253;
        else              b_sel[i] = 192 + $urandom % 8;
        b_comp[i] = $urandom % 4;
      end
      send($sformatf("R7 R9 R10 R11 R12 random %0d", n), model());
      if ($urandom % 4 == 0) @(negedge clk);
    end

    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    check("R1 all verdicts delivered", 6'(exp_q.size()), 6'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule